// File: doc/BRIEF.md
# Single-Precision Rounding and Exception Packer

This block is the last stage of a single-precision floating-point datapath. An upstream arithmetic unit delivers an unrounded result: a sign, an unbiased exponent held as a 10-bit two's-complement number, and a normalized 26-bit significand. The significand holds the leading integer bit, 23 fraction bits, one guard bit and one sticky bit. The packer applies one of five rounding modes, which arrive as a one-hot vector. It denormalizes results that fall below the normal range and saturates results that leave it. It then emits the 32-bit encoded word along with the overflow, underflow and inexact flags.

The block is purely combinational. Special operands are not its concern. When the upstream stage has already settled on a NaN, an infinity or a zero, it raises the bypass input with that word. The packer then passes the word through with all three flags cleared.

Top module: `f32_round_pack`

## Requirements
- R1: The output word is {sign, 8-bit biased exponent, 23-bit fraction}, and the biased exponent equals the input exponent plus 127. A value that fits exactly is packed with all flags clear. Significand layout: bit 25 is the integer bit, bits 24..2 are the fraction, bit 1 is guard and bit 0 is sticky.
- R2: Rounding mode bit 0 selects nearest, ties to even. On an exact half-way tie the result stays on the even fraction; above half it rounds up; below half it truncates.
- R3: Mode bit 1 selects nearest, ties away from zero. Bit 2 rounds toward +inf, bit 3 toward -inf and bit 4 toward zero. Any discarded bit raises inexact. For example, 2^25 + 2 gives 0x4C000000 under ties-to-even, toward -inf and toward zero, and 0x4C000001 under ties-away and toward +inf.
- R4: A rounding increment that carries out of the fraction bumps the exponent and clears the fraction.
- R5: On overflow (a rounded biased exponent of 255 or more), overflow and inexact are raised. Both nearest modes give infinity of the result's sign. Toward +inf gives +inf or 0xFF7FFFFF. Toward -inf gives 0x7F7FFFFF or -inf.
- R6: Toward zero never yields infinity: an overflow there gives the largest finite magnitude of the result's sign, and a value that truncates to 0x7F7FFFFF is not an overflow.
- R7: A nonzero value whose biased exponent is 0 or below before rounding is tiny. Tiny and inexact raises underflow, even when rounding lifts it to the smallest normal. Under underflow the output is a subnormal, a zero or the smallest normal.
- R8: The smallest normal magnitude of a given sign comes out of an underflow only under the nearest modes or the directed mode toward that sign's infinity.
- R9: A tiny value that is exact packs as a subnormal (or the smallest normal when already there) with all flags clear.
- R10: A zero significand gives a zero of the input sign with all flags clear, whatever the exponent.
- R11: With bypass high, the output is the bypass word and all three flags are clear.
- R12: Overflow or underflow never appears without inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the unrounded result |
| exp_i | input | 10 | Unbiased exponent, two's complement |
| mant_i | input | 26 | Integer bit, fraction, guard, sticky |
| rmode_i | input | 5 | One-hot rounding mode (bit0 even, bit1 away, bit2 +inf, bit3 -inf, bit4 zero) |
| bypass_i | input | 1 | Force the output to bypass_val_i |
| bypass_val_i | input | 32 | Special word used under bypass |
| result_o | output | 32 | Encoded single-precision result |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inx_o | output | 1 | Inexact flag |

## Verification
Two functions can act on the same operand: the rounding increment and range handling. At the top, an all-ones significand at exponent 127 carries into exponent 255, so nearest modes must report overflow while toward-zero gives 0x7F7FFFFF with only inexact. At the bottom, an all-ones significand at exponent -127 rounds up into the smallest normal yet must still raise underflow. The bench applies each such operand under several modes and both signs, and compares the word and all three flags against hand-derived values.

// File: rtl/f32rp_pkg.sv
package f32rp_pkg;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int IN_EXP_W = 10;
  localparam int RM_W     = 5;

  // one-hot rounding-mode bit positions
  localparam int RM_EVEN = 0;
  localparam int RM_AWAY = 1;
  localparam int RM_POS  = 2;
  localparam int RM_NEG  = 3;
  localparam int RM_ZERO = 4;

  localparam int SIG_W  = FRAC_W + 1;
  localparam int MANT_W = SIG_W + 2;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
endpackage

// File: rtl/f32rp_align.sv
module f32rp_align
  import f32rp_pkg::*;
#(
  parameter int P_EXP_W    = EXP_W,
  parameter int P_FRAC_W   = FRAC_W,
  parameter int P_IN_EXP_W = IN_EXP_W
) (
  input  logic [P_IN_EXP_W-1:0]  exp_i,
  input  logic [P_FRAC_W+2:0]    mant_i,
  output logic [P_FRAC_W:0]      keep_o,
  output logic                   guard_o,
  output logic                   sticky_o,
  output logic [P_IN_EXP_W:0]    efield_o,
  output logic                   tiny_o,
  output logic                   zero_o
);
  localparam int L_SIG_W  = P_FRAC_W + 1;
  localparam int L_MANT_W = L_SIG_W + 2;
  localparam int L_BE_W   = P_IN_EXP_W + 2;
  localparam int L_EF_W   = L_BE_W - 1;
  localparam int L_BIAS   = (1 << (P_EXP_W - 1)) - 1;
  localparam int L_SH_W   = $clog2(L_MANT_W + 1);
  localparam int L_EXT_W  = 2 * L_MANT_W;

  logic signed [L_BE_W-1:0] exp_ext;
  logic signed [L_BE_W-1:0] bexp;
  logic        [L_BE_W-1:0] deficit;
  logic        [L_SH_W-1:0] shamt;
  logic                     below;

  always_comb begin
    exp_ext = {{(L_BE_W - P_IN_EXP_W){exp_i[P_IN_EXP_W-1]}}, exp_i};
    bexp    = exp_ext + L_BE_W'(L_BIAS);
    below   = bexp[L_BE_W-1] || (bexp == '0);
    deficit = L_BE_W'(1) - bexp;
    if (!below)
      shamt = '0;
    else if (deficit > L_BE_W'(L_MANT_W))
      shamt = L_SH_W'(L_MANT_W);
    else
      shamt = deficit[L_SH_W-1:0];
  end

  // logarithmic right shifter over a zero-padded window; nothing is lost
  // because the shift never exceeds the pad width
  logic [L_EXT_W-1:0] stage [0:L_SH_W];
  assign stage[0] = {mant_i, {L_MANT_W{1'b0}}};

  genvar gi;
  generate
    for (gi = 0; gi < L_SH_W; gi++) begin : g_shift
      assign stage[gi+1] = shamt[gi] ? (stage[gi] >> (1 << gi)) : stage[gi];
    end
  endgenerate

  logic [L_EXT_W-1:0] shifted;
  logic [L_BE_W-1:0]  ef_norm;

  always_comb begin
    shifted  = stage[L_SH_W];
    keep_o   = shifted[L_EXT_W-1 -: L_SIG_W];
    guard_o  = shifted[L_EXT_W-1-L_SIG_W];
    sticky_o = |shifted[L_EXT_W-2-L_SIG_W:0];
    zero_o   = (mant_i == '0);
    tiny_o   = below && !zero_o;
    ef_norm  = bexp - L_BE_W'(1);
    if (below || zero_o)
      efield_o = '0;
    else
      efield_o = ef_norm[L_EF_W-1:0];
  end

  logic unused_ok;
  assign unused_ok = ef_norm[L_BE_W-1];
endmodule

// File: rtl/f32rp_incr.sv
module f32rp_incr
  import f32rp_pkg::*;
(
  input  logic [RM_W-1:0] rmode_i,
  input  logic            sign_i,
  input  logic            lsb_i,
  input  logic            guard_i,
  input  logic            sticky_i,
  output logic            inc_o,
  output logic            inexact_o
);
  logic lost;
  logic up_even, up_away, up_pos, up_neg;

  always_comb begin
    lost      = guard_i | sticky_i;
    up_even   = rmode_i[RM_EVEN] & guard_i & (sticky_i | lsb_i);
    up_away   = rmode_i[RM_AWAY] & guard_i;
    up_pos    = rmode_i[RM_POS]  & ~sign_i & lost;
    up_neg    = rmode_i[RM_NEG]  &  sign_i & lost;
    inc_o     = (up_even | up_away | up_pos | up_neg) & ~rmode_i[RM_ZERO];
    inexact_o = lost;
  end
endmodule

// File: rtl/f32rp_pack.sv
module f32rp_pack
  import f32rp_pkg::*;
#(
  parameter int P_EXP_W    = EXP_W,
  parameter int P_FRAC_W   = FRAC_W,
  parameter int P_IN_EXP_W = IN_EXP_W
) (
  input  logic                            sign_i,
  input  logic [P_IN_EXP_W:0]             efield_i,
  input  logic [P_FRAC_W:0]               keep_i,
  input  logic                            inc_i,
  input  logic                            inexact_i,
  input  logic                            tiny_i,
  input  logic [RM_W-1:0]                 rmode_i,
  input  logic                            bypass_i,
  input  logic [P_EXP_W+P_FRAC_W:0]       bypass_val_i,
  output logic [P_EXP_W+P_FRAC_W:0]       result_o,
  output logic                            ovf_o,
  output logic                            unf_o,
  output logic                            inx_o
);
  localparam int L_EF_W   = P_IN_EXP_W + 1;
  localparam int L_SUM_W  = L_EF_W + P_FRAC_W;
  localparam int L_WORD_W = 1 + P_EXP_W + P_FRAC_W;
  localparam int L_EMAX   = (1 << P_EXP_W) - 1;

  logic [L_SUM_W-1:0]  sum;
  logic [L_EF_W-1:0]   sum_exp;
  logic                over;
  logic                to_inf;
  logic [L_WORD_W-1:0] sat_word;
  logic [L_WORD_W-1:0] fin_word;

  always_comb begin
    // exponent field and significand share one adder so a fraction carry
    // lands in the exponent, including subnormal to normal and max to inf
    sum     = {efield_i, {P_FRAC_W{1'b0}}}
            + L_SUM_W'(keep_i)
            + L_SUM_W'(inc_i);
    sum_exp = sum[L_SUM_W-1:P_FRAC_W];
    over    = (sum_exp >= L_EF_W'(L_EMAX));

    to_inf  = (rmode_i[RM_EVEN] | rmode_i[RM_AWAY]
            | (rmode_i[RM_POS] & ~sign_i)
            | (rmode_i[RM_NEG] &  sign_i)) & ~rmode_i[RM_ZERO];

    if (to_inf)
      sat_word = {sign_i, {P_EXP_W{1'b1}}, {P_FRAC_W{1'b0}}};
    else
      sat_word = {sign_i, {(P_EXP_W-1){1'b1}}, 1'b0, {P_FRAC_W{1'b1}}};

    fin_word = {sign_i, sum[P_EXP_W+P_FRAC_W-1:0]};

    if (bypass_i) begin
      result_o = bypass_val_i;
      ovf_o    = 1'b0;
      unf_o    = 1'b0;
      inx_o    = 1'b0;
    end else if (over) begin
      result_o = sat_word;
      ovf_o    = 1'b1;
      unf_o    = 1'b0;
      inx_o    = 1'b1;
    end else begin
      result_o = fin_word;
      ovf_o    = 1'b0;
      unf_o    = tiny_i & inexact_i;
      inx_o    = inexact_i;
    end
  end
endmodule

// File: rtl/f32_round_pack.sv
module f32_round_pack
  import f32rp_pkg::*;
(
  input  logic                sign_i,
  input  logic [IN_EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]   mant_i,
  input  logic [RM_W-1:0]     rmode_i,
  input  logic                bypass_i,
  input  logic [WORD_W-1:0]   bypass_val_i,
  output logic [WORD_W-1:0]   result_o,
  output logic                ovf_o,
  output logic                unf_o,
  output logic                inx_o
);
  logic [SIG_W-1:0]  keep;
  logic              guard, sticky, tiny, is_zero;
  logic [IN_EXP_W:0] efield;
  logic              inc, inexact;

  f32rp_align #(
    .P_EXP_W(EXP_W), .P_FRAC_W(FRAC_W), .P_IN_EXP_W(IN_EXP_W)
  ) u_align (
    .exp_i    (exp_i),
    .mant_i   (mant_i),
    .keep_o   (keep),
    .guard_o  (guard),
    .sticky_o (sticky),
    .efield_o (efield),
    .tiny_o   (tiny),
    .zero_o   (is_zero)
  );

  f32rp_incr u_incr (
    .rmode_i   (rmode_i),
    .sign_i    (sign_i),
    .lsb_i     (keep[0]),
    .guard_i   (guard),
    .sticky_i  (sticky),
    .inc_o     (inc),
    .inexact_o (inexact)
  );

  f32rp_pack #(
    .P_EXP_W(EXP_W), .P_FRAC_W(FRAC_W), .P_IN_EXP_W(IN_EXP_W)
  ) u_pack (
    .sign_i       (sign_i),
    .efield_i     (efield),
    .keep_i       (keep),
    .inc_i        (inc),
    .inexact_i    (inexact),
    .tiny_i       (tiny),
    .rmode_i      (rmode_i),
    .bypass_i     (bypass_i),
    .bypass_val_i (bypass_val_i),
    .result_o     (result_o),
    .ovf_o        (ovf_o),
    .unf_o        (unf_o),
    .inx_o        (inx_o)
  );

  logic unused_ok;
  assign unused_ok = is_zero;
endmodule

// File: rtl/f32_round_pack_chk.sv
module f32_round_pack_chk
  import f32rp_pkg::*;
(
  input logic                sign_i,
  input logic [RM_W-1:0]     rmode_i,
  input logic                bypass_i,
  input logic [WORD_W-1:0]   bypass_val_i,
  input logic [WORD_W-1:0]   result_o,
  input logic                ovf_o,
  input logic                unf_o,
  input logic                inx_o
);
  logic [EXP_W-1:0]  r_exp;
  logic [FRAC_W-1:0] r_frac;
  logic              r_inf, r_ebmin, r_sub;
  logic [WORD_W-1:0] pos_max, neg_max, pos_inf, neg_inf;

  always_comb begin
    r_exp   = result_o[WORD_W-2 -: EXP_W];
    r_frac  = result_o[FRAC_W-1:0];
    r_inf   = (r_exp == '1) && (r_frac == '0);
    r_ebmin = (r_exp == EXP_W'(1)) && (r_frac == '0);
    r_sub   = (r_exp == '0) && (r_frac != '0);
    pos_max = {1'b0, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    neg_max = {1'b1, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    pos_inf = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    neg_inf = {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  end

  always_comb begin
    a_r12_ovf_inexact: assert (!ovf_o || inx_o);
    a_r12_unf_inexact: assert (!unf_o || inx_o);
    a_r7_unf_range:    assert (!unf_o || r_exp == '0 || r_ebmin);
    a_r11_bypass:      assert (!bypass_i ||
                               (result_o == bypass_val_i && !ovf_o && !unf_o && !inx_o));
    a_r6_zero_no_inf:  assert (bypass_i || !$onehot(rmode_i) || !rmode_i[RM_ZERO] || !r_inf);
    a_r9_sub_exact:    assert (bypass_i || !r_sub || unf_o || !inx_o);
    a_r9_inf_exact:    assert (bypass_i || !r_inf || ovf_o || !inx_o);
    if ($onehot(rmode_i) && ovf_o) begin
      a_r5_ovf_value: assert (
        ((rmode_i[RM_EVEN] || rmode_i[RM_AWAY]) && r_inf && result_o[WORD_W-1] == sign_i) ||
        (rmode_i[RM_POS]  && (result_o == pos_inf || result_o == neg_max)) ||
        (rmode_i[RM_NEG]  && (result_o == pos_max || result_o == neg_inf)) ||
        (rmode_i[RM_ZERO] && (result_o == pos_max || result_o == neg_max)));
    end
    if ($onehot(rmode_i) && unf_o && r_ebmin) begin
      a_r8_ebmin_mode: assert (rmode_i[RM_EVEN] || rmode_i[RM_AWAY] ||
                               (result_o[WORD_W-1] ? rmode_i[RM_NEG] : rmode_i[RM_POS]));
    end
  end
endmodule

bind f32_round_pack f32_round_pack_chk u_chk (
  .sign_i       (sign_i),
  .rmode_i      (rmode_i),
  .bypass_i     (bypass_i),
  .bypass_val_i (bypass_val_i),
  .result_o     (result_o),
  .ovf_o        (ovf_o),
  .unf_o        (unf_o),
  .inx_o        (inx_o)
);

// File: tb/f32_round_pack_tb.sv
module f32_round_pack_tb;
  localparam logic [4:0] EV = 5'b00001;
  localparam logic [4:0] AW = 5'b00010;
  localparam logic [4:0] UP = 5'b00100;
  localparam logic [4:0] DN = 5'b01000;
  localparam logic [4:0] TZ = 5'b10000;

  typedef struct packed {
    logic        sgn;
    logic [9:0]  ex;
    logic [25:0] mt;
    logic [4:0]  rm;
    logic        byp;
    logic [31:0] bval;
    logic [31:0] res;
    logic [2:0]  flg;   // {ovf, unf, inx}
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h000, 26'h2000000, EV, 1'b0, 32'h0, 32'h3F800000, 3'b000, 8'd1},  // R1
    '{1'b0, 10'h07F, 26'h3FFFFFC, EV, 1'b0, 32'h0, 32'h7F7FFFFF, 3'b000, 8'd1},  // R1
    '{1'b0, 10'h019, 26'h2000002, EV, 1'b0, 32'h0, 32'h4C000000, 3'b001, 8'd2},  // R2
    '{1'b0, 10'h019, 26'h2000006, EV, 1'b0, 32'h0, 32'h4C000002, 3'b001, 8'd2},  // R2
    '{1'b0, 10'h019, 26'h2000003, EV, 1'b0, 32'h0, 32'h4C000001, 3'b001, 8'd2},  // R2
    '{1'b0, 10'h019, 26'h2000001, EV, 1'b0, 32'h0, 32'h4C000000, 3'b001, 8'd2},  // R2
    '{1'b1, 10'h019, 26'h2000002, EV, 1'b0, 32'h0, 32'hCC000000, 3'b001, 8'd2},  // R2
    '{1'b0, 10'h019, 26'h2000002, AW, 1'b0, 32'h0, 32'h4C000001, 3'b001, 8'd3},  // R3
    '{1'b0, 10'h019, 26'h2000002, UP, 1'b0, 32'h0, 32'h4C000001, 3'b001, 8'd3},  // R3
    '{1'b0, 10'h019, 26'h2000002, DN, 1'b0, 32'h0, 32'h4C000000, 3'b001, 8'd3},  // R3
    '{1'b0, 10'h019, 26'h2000002, TZ, 1'b0, 32'h0, 32'h4C000000, 3'b001, 8'd3},  // R3
    '{1'b1, 10'h019, 26'h2000002, AW, 1'b0, 32'h0, 32'hCC000001, 3'b001, 8'd3},  // R3
    '{1'b1, 10'h019, 26'h2000002, UP, 1'b0, 32'h0, 32'hCC000000, 3'b001, 8'd3},  // R3
    '{1'b1, 10'h019, 26'h2000002, DN, 1'b0, 32'h0, 32'hCC000001, 3'b001, 8'd3},  // R3
    '{1'b1, 10'h019, 26'h2000002, TZ, 1'b0, 32'h0, 32'hCC000000, 3'b001, 8'd3},  // R3
    '{1'b0, 10'h019, 26'h2000006, TZ, 1'b0, 32'h0, 32'h4C000001, 3'b001, 8'd3},  // R3
    '{1'b0, 10'h019, 26'h2000001, UP, 1'b0, 32'h0, 32'h4C000001, 3'b001, 8'd3},  // R3
    '{1'b1, 10'h019, 26'h2000001, DN, 1'b0, 32'h0, 32'hCC000001, 3'b001, 8'd3},  // R3
    '{1'b0, 10'h000, 26'h3FFFFFE, EV, 1'b0, 32'h0, 32'h40000000, 3'b001, 8'd4},  // R4
    '{1'b0, 10'h080, 26'h2000000, EV, 1'b0, 32'h0, 32'h7F800000, 3'b101, 8'd5},  // R5
    '{1'b0, 10'h080, 26'h2000000, UP, 1'b0, 32'h0, 32'h7F800000, 3'b101, 8'd5},  // R5
    '{1'b0, 10'h080, 26'h2000000, DN, 1'b0, 32'h0, 32'h7F7FFFFF, 3'b101, 8'd5},  // R5
    '{1'b1, 10'h080, 26'h2000000, UP, 1'b0, 32'h0, 32'hFF7FFFFF, 3'b101, 8'd5},  // R5
    '{1'b1, 10'h080, 26'h2000000, DN, 1'b0, 32'h0, 32'hFF800000, 3'b101, 8'd5},  // R5
    '{1'b1, 10'h1FF, 26'h2000000, AW, 1'b0, 32'h0, 32'hFF800000, 3'b101, 8'd5},  // R5
    '{1'b0, 10'h07F, 26'h3FFFFFE, EV, 1'b0, 32'h0, 32'h7F800000, 3'b101, 8'd5},  // R5
    '{1'b0, 10'h0C8, 26'h2000000, TZ, 1'b0, 32'h0, 32'h7F7FFFFF, 3'b101, 8'd6},  // R6
    '{1'b1, 10'h080, 26'h2000000, TZ, 1'b0, 32'h0, 32'hFF7FFFFF, 3'b101, 8'd6},  // R6
    '{1'b0, 10'h07F, 26'h3FFFFFE, TZ, 1'b0, 32'h0, 32'h7F7FFFFF, 3'b001, 8'd6},  // R6
    '{1'b0, 10'h381, 26'h3FFFFFE, EV, 1'b0, 32'h0, 32'h00800000, 3'b011, 8'd7},  // R7
    '{1'b0, 10'h381, 26'h3FFFFFE, TZ, 1'b0, 32'h0, 32'h007FFFFF, 3'b011, 8'd7},  // R7
    '{1'b0, 10'h360, 26'h2000000, EV, 1'b0, 32'h0, 32'h00000000, 3'b011, 8'd7},  // R7
    '{1'b0, 10'h36A, 26'h2000000, EV, 1'b0, 32'h0, 32'h00000000, 3'b011, 8'd7},  // R7
    '{1'b0, 10'h36A, 26'h2000000, AW, 1'b0, 32'h0, 32'h00000001, 3'b011, 8'd7},  // R7
    '{1'b0, 10'h36B, 26'h2000002, UP, 1'b0, 32'h0, 32'h00000002, 3'b011, 8'd7},  // R7
    '{1'b0, 10'h381, 26'h3FFFFFE, UP, 1'b0, 32'h0, 32'h00800000, 3'b011, 8'd8},  // R8
    '{1'b0, 10'h381, 26'h3FFFFFE, DN, 1'b0, 32'h0, 32'h007FFFFF, 3'b011, 8'd8},  // R8
    '{1'b1, 10'h381, 26'h3FFFFFE, DN, 1'b0, 32'h0, 32'h80800000, 3'b011, 8'd8},  // R8
    '{1'b1, 10'h381, 26'h3FFFFFE, UP, 1'b0, 32'h0, 32'h807FFFFF, 3'b011, 8'd8},  // R8
    '{1'b0, 10'h382, 26'h2000000, EV, 1'b0, 32'h0, 32'h00800000, 3'b000, 8'd9},  // R9
    '{1'b0, 10'h381, 26'h2000000, EV, 1'b0, 32'h0, 32'h00400000, 3'b000, 8'd9},  // R9
    '{1'b1, 10'h36B, 26'h2000000, UP, 1'b0, 32'h0, 32'h80000001, 3'b000, 8'd9},  // R9
    '{1'b1, 10'h12C, 26'h0000000, EV, 1'b0, 32'h0, 32'h80000000, 3'b000, 8'd10}, // R10
    '{1'b0, 10'h080, 26'h2000001, EV, 1'b1, 32'h7FC00000, 32'h7FC00000, 3'b000, 8'd11} // R11
  };

  logic        clk;
  logic        sign_i;
  logic [9:0]  exp_i;
  logic [25:0] mant_i;
  logic [4:0]  rmode_i;
  logic        bypass_i;
  logic [31:0] bypass_val_i;
  logic [31:0] result_o;
  logic        ovf_o, unf_o, inx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  f32_round_pack u_dut (
    .sign_i(sign_i), .exp_i(exp_i), .mant_i(mant_i), .rmode_i(rmode_i),
    .bypass_i(bypass_i), .bypass_val_i(bypass_val_i),
    .result_o(result_o), .ovf_o(ovf_o), .unf_o(unf_o), .inx_o(inx_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic apply(input logic s, input logic [9:0] e, input logic [25:0] m,
                       input logic [4:0] r, input logic b, input logic [31:0] bv);
    @(negedge clk);
    sign_i = s; exp_i = e; mant_i = m; rmode_i = r; bypass_i = b; bypass_val_i = bv;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input int req, input logic [31:0] er, input logic [2:0] ef);
    checks++;
    if (result_o !== er || {ovf_o, unf_o, inx_o} !== ef) begin
      fails++;
      $display("FAIL R%0d: got %08h flags %03b, expected %08h flags %03b",
               req, result_o, {ovf_o, unf_o, inx_o}, er, ef);
    end
  endtask

  initial begin
    sign_i = 1'b0; exp_i = '0; mant_i = '0; rmode_i = EV;
    bypass_i = 1'b0; bypass_val_i = '0;

    // idle state: all-zero significand gives +0 with no flags (R10)
    @(posedge clk); #2;
    check(10, 32'h00000000, 3'b000);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].sgn, VECS[i].ex, VECS[i].mt, VECS[i].rm, VECS[i].byp, VECS[i].bval);
      check(int'(VECS[i].req), VECS[i].res, VECS[i].flg);
    end

    // R11: bypass over an underflowing operand, negative infinity word
    apply(1'b0, 10'h360, 26'h2000000, UP, 1'b1, 32'hFF800000);
    check(11, 32'hFF800000, 3'b000);
    // R11: release bypass with same operand: normal path returns
    apply(1'b0, 10'h360, 26'h2000000, UP, 1'b0, 32'hFF800000);
    check(7, 32'h00000001, 3'b011);
    // R12: same overflowing operand walked across all modes, inexact always set
    for (int k = 0; k < 5; k++) begin
      apply(1'b1, 10'h0C8, 26'h2000000, 5'(1 << k), 1'b0, 32'h0);
      check(12, (k == 0 || k == 1 || k == 3) ? 32'hFF800000 : 32'hFF7FFFFF, 3'b101);
    end
    // R10: zero significand under a tiny exponent and directed mode
    apply(1'b0, 10'h360, 26'h0000000, UP, 1'b0, 32'h0);
    check(10, 32'h00000000, 3'b000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule